// File: doc/BRIEF.md
# Dual-Edge to Single-Edge Receive Converter

This stage sits at the receive side of a router port. It is fed by a link that carries two flits in each clock cycle. One flit arrives in the rising-edge slot and the other in the falling-edge slot. Each slot has its own valid bit, virtual-channel index and payload.

The stage does not use double-edge flip-flops. It captures the rising-edge slot in a register clocked on the rising edge and the falling-edge slot in a register clocked on the falling edge. A per-VC multiplexer then steers both captured flits to the write ports of the virtual-channel FIFOs. The FIFOs take the write on the next rising edge, so the stage adds one cycle of latency.

The stage only captures, steers and writes. The FIFOs, credit return and routing sit outside it. The link is expected to deliver the two flits of a cycle to different VCs. If both valid flits name the same VC, the stage flags it and keeps the rising-edge flit.

Top module: `d2s_rx_stage`

## Requirements
- R1: A flit presented in the rising-edge slot (`pos_*`) at rising edge k drives `vc_we` and its lane of `vc_wdata` from the falling edge that follows until rising edge k+1, where the FIFO writes it. The VC index is a binary number, and lane v occupies bits [v*FLIT_W +: FLIT_W].
- R2: A flit presented in the falling-edge slot (`neg_*`) at the falling edge between rising edges k and k+1 is written at rising edge k+1, the same edge as the rising-edge flit of cycle k.
- R3: A slot whose valid bit is low raises no write enable for any VC.
- R4: When both slots are valid and name different VCs, both VCs are written in the same cycle, and each lane carries the flit of its own slot.
- R5: When both slots are valid and name the same VC, `dup_err` is high for that cycle. Only that VC is enabled, and its lane carries the rising-edge flit; the falling-edge flit is dropped.
- R6: Every lane whose write enable is low reads as zero.
- R7: An active-low reset clears all write enables and `dup_err` at once, without waiting for a clock edge.
- R8: A captured flit is written exactly once. A cycle in which both slots are invalid, following a cycle of valid flits, produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link and router clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_vld | input | 1 | Rising-edge slot carries a flit |
| pos_vc | input | VC_IDX_W | Target VC of the rising-edge flit |
| pos_flit | input | FLIT_W | Payload of the rising-edge flit |
| neg_vld | input | 1 | Falling-edge slot carries a flit |
| neg_vc | input | VC_IDX_W | Target VC of the falling-edge flit |
| neg_flit | input | FLIT_W | Payload of the falling-edge flit |
| vc_we | output | NUM_VC | Per-VC FIFO write enable |
| vc_wdata | output | NUM_VC*FLIT_W | Per-VC FIFO write data, lane v at bits [v*FLIT_W +: FLIT_W] |
| dup_err | output | 1 | Both slots named the same VC in this cycle |

## Verification
A wrong capture register shows up at the ports within half a cycle. The lane of the affected slot carries another cycle's payload, or its enable repeats in the next cycle. Since the bench sends a new payload each cycle, a stale or replayed flit is caught in the very next check. A wrong steering decision shows up at once as an enable on the wrong VC, a nonzero idle lane, or the falling-edge payload on a conflicting VC. Each cycle of the vector walk checks all four lanes.

// File: rtl/d2s_rx_pkg.sv
package d2s_rx_pkg;
    localparam int unsigned DEF_FLIT_W = 32;
    localparam int unsigned DEF_NUM_VC = 4;

    typedef enum logic {
        SLOT_RISE = 1'b0,
        SLOT_FALL = 1'b1
    } slot_edge_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/d2s_edge_reg.sv
module d2s_edge_reg
    import d2s_rx_pkg::*;
#(
    parameter int unsigned FLIT_W   = DEF_FLIT_W,
    parameter int unsigned VC_IDX_W = 2,
    parameter slot_edge_e  EDGE     = SLOT_RISE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [VC_IDX_W-1:0] in_vc,
    input  logic [FLIT_W-1:0]   in_flit,
    output logic                out_vld,
    output logic [VC_IDX_W-1:0] out_vc,
    output logic [FLIT_W-1:0]   out_flit
);
    typedef struct packed {
        logic                vld;
        logic [VC_IDX_W-1:0] vc;
        logic [FLIT_W-1:0]   flit;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d      = '0;
        slot_d.vld  = in_vld;
        slot_d.vc   = in_vc;
        slot_d.flit = in_vld ? in_flit : '0;
    end

    generate
        if (EDGE == SLOT_FALL) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end

            a_r2_fall_capture: assert property (@(negedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_vld == $past(in_vld)) &&
                                 (!out_vld || (out_flit == $past(in_flit) && out_vc == $past(in_vc))));
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end

            a_r1_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_vld == $past(in_vld)) &&
                                 (!out_vld || (out_flit == $past(in_flit) && out_vc == $past(in_vc))));
        end
    endgenerate

    assign out_vld  = slot_q.vld;
    assign out_vc   = slot_q.vc;
    assign out_flit = slot_q.flit;
endmodule

// File: rtl/d2s_vc_steer.sv
module d2s_vc_steer
    import d2s_rx_pkg::*;
#(
    parameter int unsigned FLIT_W   = DEF_FLIT_W,
    parameter int unsigned NUM_VC   = DEF_NUM_VC,
    parameter int unsigned VC_IDX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rise_vld,
    input  logic [VC_IDX_W-1:0]      rise_vc,
    input  logic [FLIT_W-1:0]        rise_flit,
    input  logic                     fall_vld,
    input  logic [VC_IDX_W-1:0]      fall_vc,
    input  logic [FLIT_W-1:0]        fall_flit,
    output logic [NUM_VC-1:0]        wr_en,
    output logic [NUM_VC*FLIT_W-1:0] wr_data,
    output logic                     clash
);
    assign clash = rise_vld && fall_vld && (rise_vc == fall_vc);

    generate
        for (genvar g = 0; g < NUM_VC; g++) begin : g_lane
            logic              hit_rise, hit_fall;
            logic [FLIT_W-1:0] lane_d;

            always_comb begin
                hit_rise = rise_vld && (rise_vc == VC_IDX_W'(g));
                hit_fall = fall_vld && (fall_vc == VC_IDX_W'(g));
                if (hit_rise)      lane_d = rise_flit;
                else if (hit_fall) lane_d = fall_flit;
                else               lane_d = '0;
            end

            assign wr_en[g]                   = hit_rise || hit_fall;
            assign wr_data[g*FLIT_W +: FLIT_W] = lane_d;

            a_r6_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en[g] |-> (wr_data[g*FLIT_W +: FLIT_W] == '0));
        end
    endgenerate
endmodule

// File: rtl/d2s_rx_stage.sv
module d2s_rx_stage
    import d2s_rx_pkg::*;
#(
    parameter int unsigned FLIT_W   = DEF_FLIT_W,
    parameter int unsigned NUM_VC   = DEF_NUM_VC,
    parameter int unsigned VC_IDX_W = idx_width(NUM_VC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pos_vld,
    input  logic [VC_IDX_W-1:0]      pos_vc,
    input  logic [FLIT_W-1:0]        pos_flit,
    input  logic                     neg_vld,
    input  logic [VC_IDX_W-1:0]      neg_vc,
    input  logic [FLIT_W-1:0]        neg_flit,
    output logic [NUM_VC-1:0]        vc_we,
    output logic [NUM_VC*FLIT_W-1:0] vc_wdata,
    output logic                     dup_err
);
    logic                r_vld, f_vld;
    logic [VC_IDX_W-1:0] r_vc,  f_vc;
    logic [FLIT_W-1:0]   r_flit, f_flit;

    d2s_edge_reg #(.FLIT_W(FLIT_W), .VC_IDX_W(VC_IDX_W), .EDGE(SLOT_RISE)) u_rise (
        .clk(clk), .rst_n(rst_n),
        .in_vld(pos_vld), .in_vc(pos_vc), .in_flit(pos_flit),
        .out_vld(r_vld), .out_vc(r_vc), .out_flit(r_flit)
    );

    d2s_edge_reg #(.FLIT_W(FLIT_W), .VC_IDX_W(VC_IDX_W), .EDGE(SLOT_FALL)) u_fall (
        .clk(clk), .rst_n(rst_n),
        .in_vld(neg_vld), .in_vc(neg_vc), .in_flit(neg_flit),
        .out_vld(f_vld), .out_vc(f_vc), .out_flit(f_flit)
    );

    d2s_vc_steer #(.FLIT_W(FLIT_W), .NUM_VC(NUM_VC), .VC_IDX_W(VC_IDX_W)) u_steer (
        .clk(clk), .rst_n(rst_n),
        .rise_vld(r_vld), .rise_vc(r_vc), .rise_flit(r_flit),
        .fall_vld(f_vld), .fall_vc(f_vc), .fall_flit(f_flit),
        .wr_en(vc_we), .wr_data(vc_wdata), .clash(dup_err)
    );

    // R3: with both captured slots empty, no FIFO is written
    a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_vld && !f_vld) |-> (vc_we == '0));

    // R4: never more writes than valid captured flits
    a_r4_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vc_we) <= (32'(r_vld) + 32'(f_vld)));

    // R5: on a clash, exactly one VC written, carrying the rising-edge flit
    a_r5_clash_keeps_rise: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |-> ($countones(vc_we) == 1) && vc_we[r_vc] &&
                    (vc_wdata[r_vc*FLIT_W +: FLIT_W] == r_flit));

    // R8: a flit is not replayed once both slots go idle
    a_r8_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_vld && !neg_vld && $past(rst_n)) |=> !r_vld);
endmodule

// File: tb/d2s_rx_stage_test.sv
module d2s_rx_stage_test;
    localparam int W  = 32;
    localparam int NV = 4;
    localparam int VW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pos_vld = 1'b0, neg_vld = 1'b0;
    logic [VW-1:0]     pos_vc = '0, neg_vc = '0;
    logic [W-1:0]      pos_flit = '0, neg_flit = '0;
    logic [NV-1:0]     vc_we;
    logic [NV*W-1:0]   vc_wdata;
    logic              dup_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    d2s_rx_stage #(.FLIT_W(W), .NUM_VC(NV), .VC_IDX_W(VW)) uut (
        .clk(clk), .rst_n(rst_n),
        .pos_vld(pos_vld), .pos_vc(pos_vc), .pos_flit(pos_flit),
        .neg_vld(neg_vld), .neg_vc(neg_vc), .neg_flit(neg_flit),
        .vc_we(vc_we), .vc_wdata(vc_wdata), .dup_err(dup_err)
    );

    // {pos_vld, pos_vc, neg_vld, neg_vc, expected we, expected dup}
    localparam int NVEC = 10;
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 1'b1, 2'd1, 4'b0011, 1'b0},
        {1'b1, 2'd2, 1'b1, 2'd3, 4'b1100, 1'b0},
        {1'b1, 2'd3, 1'b0, 2'd1, 4'b1000, 1'b0},
        {1'b0, 2'd1, 1'b1, 2'd0, 4'b0001, 1'b0},
        {1'b0, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b0},
        {1'b1, 2'd1, 1'b1, 2'd1, 4'b0010, 1'b1},
        {1'b1, 2'd2, 1'b1, 2'd0, 4'b0101, 1'b0},
        {1'b0, 2'd2, 1'b0, 2'd3, 4'b0000, 1'b0},
        {1'b1, 2'd0, 1'b1, 2'd3, 4'b1001, 1'b0},
        {1'b1, 2'd3, 1'b1, 2'd3, 4'b1000, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Rising slot sampled at next posedge, falling slot at the negedge after it;
    // returns half-way through the output window.
    task automatic send(input logic pv, input logic [VW-1:0] pc, input logic [W-1:0] pd,
                        input logic nv, input logic [VW-1:0] nc, input logic [W-1:0] nd);
        pos_vld = pv; pos_vc = pc; pos_flit = pd;
        @(posedge clk);
        #1;
        neg_vld = nv; neg_vc = nc; neg_flit = nd;
        pos_vld = 1'b0; pos_flit = '0;
        @(negedge clk);
        #2;
        neg_vld = 1'b0; neg_flit = '0;
    endtask

    task automatic check_lanes(input logic pv, input logic [VW-1:0] pc, input logic [W-1:0] pd,
                               input logic nv, input logic [VW-1:0] nc, input logic [W-1:0] nd);
        for (int v = 0; v < NV; v++) begin
            if (pv && pc == VW'(v))
                check("R1", $sformatf("lane %0d rise flit", v), vc_wdata[v*W +: W], pd);
            else if (nv && nc == VW'(v))
                check("R2", $sformatf("lane %0d fall flit", v), vc_wdata[v*W +: W], nd);
            else
                check("R6", $sformatf("lane %0d idle", v), vc_wdata[v*W +: W], '0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R7", "we in reset", W'(vc_we), '0);
        check("R7", "dup in reset", W'(dup_err), '0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;

        // vector walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic          pv, nv, ed;
            logic [VW-1:0] pc, nc;
            logic [NV-1:0] ew;
            logic [W-1:0]  pd, nd;
            string         rq;
            {pv, pc, nv, nc, ew, ed} = VEC[i];
            pd = 32'hA500_0000 + W'(i);
            nd = 32'h5A00_0000 + W'(i * 3);
            send(pv, pc, pd, nv, nc, nd);
            rq = ed ? "R5" : (ew == '0) ? "R3" : "R4";
            check(rq, $sformatf("vec %0d we", i), W'(vc_we), W'(ew));
            check("R5", $sformatf("vec %0d dup", i), W'(dup_err), W'(ed));
            check_lanes(pv, pc, pd, nv && !ed, nc, nd);
        end

        // R8: valid cycle followed by an idle cycle writes nothing
        send(1'b1, 2'd1, 32'hCAFE_0001, 1'b1, 2'd2, 32'hCAFE_0002);
        check("R4", "pre-idle we", W'(vc_we), W'(4'b0110));
        send(1'b0, 2'd1, 32'hDEAD_0001, 1'b0, 2'd2, 32'hDEAD_0002);
        check("R8", "idle after valid we", W'(vc_we), '0);
        check("R8", "idle after valid lane1", vc_wdata[1*W +: W], '0);

        // R3: invalid slots carrying a VC index and payload still write nothing
        send(1'b0, 2'd3, 32'h1111_1111, 1'b0, 2'd0, 32'h2222_2222);
        check("R3", "invalid slots we", W'(vc_we), '0);
        check("R3", "invalid slot lane3", vc_wdata[3*W +: W], '0);

        // R2: same VC in consecutive cycles keeps arrival order
        send(1'b0, 2'd0, '0, 1'b1, 2'd2, 32'h0000_00F1);
        check("R2", "order first lane2", vc_wdata[2*W +: W], 32'h0000_00F1);
        send(1'b1, 2'd2, 32'h0000_00F2, 1'b0, 2'd0, '0);
        check("R1", "order second lane2", vc_wdata[2*W +: W], 32'h0000_00F2);

        // R7: asynchronous reset while a write is pending
        send(1'b1, 2'd0, 32'h7777_0000, 1'b1, 2'd3, 32'h7777_0003);
        check("R4", "before reset we", W'(vc_we), W'(4'b1001));
        rst_n = 1'b0;
        #1;
        check("R7", "we after async reset", W'(vc_we), '0);
        check("R7", "lane0 after async reset", vc_wdata[0*W +: W], '0);
        send(1'b1, 2'd1, 32'h3333_3333, 1'b1, 2'd1, 32'h4444_4444);
        check("R7", "dup held in reset", W'(dup_err), '0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        send(1'b1, 2'd1, 32'h3333_3333, 1'b0, 2'd0, '0);
        check("R1", "first after reset we", W'(vc_we), W'(4'b0010));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule